// File: doc/BRIEF.md
# Doorbell Mailbox Register Unit

This block lets two processors signal each other through single-bit doorbells. It has three physical channels: channel 0 is low priority, channel 1 is high priority and channel 2 is secure. Each channel holds an inbound word and an outbound word. Every bit of those words is one independent doorbell. The local host reaches every word through a zero-wait APB-style register port. For each word the host sees a status register, a bit-wise set strobe and a bit-wise clear strobe.

A peer-side port raises inbound doorbells and retires outbound doorbells. Each channel drives one level interrupt towards the local host. The interrupt is high while that channel's inbound word is non-zero. A sender knows a doorbell was taken when it polls the outbound status and finds the bit back at zero. A read-only identification register completes the map.

Top module: `dbmb_unit`

## Requirements
- R1: After reset all six doorbell words read zero, `irq` is 3'b000, `pready` is 1 and `pslverr` is 0.
- R2: The register groups sit at these channel bases: 0x000 for channel 0 (low priority), 0x020 for channel 1 (high priority) and 0x200 for channel 2 (secure). The inbound group is at the base and the outbound group is at base+0x100. Inside each group, status is at +0x00, set is at +0x08 and clear is at +0x10.
- R3: Writing a value to a set register raises every doorbell whose bit is 1 in that value. Doorbells whose bit is 0 keep their state.
- R4: Writing a value to a clear register lowers every doorbell whose bit is 1 in that value. Doorbells whose bit is 0 keep their state.
- R5: A one-cycle pulse on `rmt_rx_set[c*32+n]` raises inbound doorbell n of channel c. A pulse on `rmt_tx_clr[c*32+n]` lowers outbound doorbell n of channel c, which the local sender then reads back as zero.
- R6: If a doorbell is raised and lowered in the same cycle, one request coming from each port, the doorbell ends up raised.
- R7: `irq[c]` is high while any inbound doorbell of channel c is one. It falls in the cycle after the last inbound doorbell is lowered. Outbound doorbells never drive it.
- R8: Reads of set and clear registers return zero.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets change no doorbell. Every access completes with `pready`=1 and `pslverr`=0.
- R10: The identification register at 0xFF0 reads 0x001BB098, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| rmt_rx_set | input | 96 | Peer raises inbound doorbells, bit c*32+n |
| rmt_tx_clr | input | 96 | Peer lowers outbound doorbells, bit c*32+n |
| irq | output | 3 | Per-channel level interrupt |

## Verification
The bench builds the unit with its default parameters: three channels of 32 doorbells, the channel bases listed in R2, and the set-priority variant. With these values bit 31 of every word can be reached. So can the widely spaced secure group, whose outbound status sits at 0x300. The set-priority variant is what allows R6 to be checked by colliding a local clear with a peer set, and a local set with a peer clear, in the same cycle.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
   localparam int BUS_W   = 32;
   localparam int OFS_ST  = 'h00;
   localparam int OFS_SET = 'h08;
   localparam int OFS_CLR = 'h10;
   typedef enum logic [1:0] {K_NONE, K_STAT, K_SET, K_CLR} reg_kind_e;
endpackage

// File: rtl/dbmb_word.sv
module dbmb_word #(
   parameter int DW       = 32,
   parameter bit SET_PRIO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] set_v,
   input  logic [DW-1:0] clr_v,
   output logic [DW-1:0] q
);
   logic [DW-1:0] nxt;

   generate
      if (SET_PRIO) begin : g_set_wins
         assign nxt = (q & ~clr_v) | set_v;
      end else begin : g_clr_wins
         assign nxt = (q | set_v) & ~clr_v;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   generate
      if (SET_PRIO) begin : g_prio_chk
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((q & $past(set_v & clr_v)) == $past(set_v & clr_v))); // R6
      end
   endgenerate

   AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((q ^ $past(q)) & ~$past(set_v | clr_v)) == '0)); // R3
endmodule

// File: rtl/dbmb_decode.sv
module dbmb_decode
   import dbmb_pkg::*;
#(
   parameter int                      NCH     = 3,
   parameter int                      AW      = 12,
   parameter logic [NCH-1:0][AW-1:0]  CH_BASE = {12'h200, 12'h020, 12'h000},
   parameter logic [AW-1:0]           TX_OFS  = 12'h100,
   parameter logic [AW-1:0]           ID_OFS  = 12'hFF0,
   localparam int                     NW      = 2 * NCH
) (
   input  logic [AW-1:0] addr,
   output logic [NW-1:0] m_stat,
   output logic [NW-1:0] m_set,
   output logic [NW-1:0] m_clr,
   output logic          m_id,
   output reg_kind_e     kind
);
   for (genvar w = 0; w < NW; w++) begin : g_word
      localparam logic [AW-1:0] WBASE = CH_BASE[w/2] + (((w % 2) == 1) ? TX_OFS : '0);
      assign m_stat[w] = (addr == WBASE + AW'(OFS_ST));
      assign m_set[w]  = (addr == WBASE + AW'(OFS_SET));
      assign m_clr[w]  = (addr == WBASE + AW'(OFS_CLR));
   end

   assign m_id = (addr == ID_OFS);

   always_comb begin
      kind = K_NONE;
      if (|m_stat)     kind = K_STAT;
      else if (|m_set) kind = K_SET;
      else if (|m_clr) kind = K_CLR;
   end
endmodule

// File: rtl/dbmb_unit.sv
module dbmb_unit
   import dbmb_pkg::*;
#(
   parameter int                      NCH      = 3,
   parameter int                      DW       = 32,
   parameter int                      AW       = 12,
   parameter logic [NCH-1:0][AW-1:0]  CH_BASE  = {12'h200, 12'h020, 12'h000},
   parameter logic [AW-1:0]           TX_OFS   = 12'h100,
   parameter logic [AW-1:0]           ID_OFS   = 12'hFF0,
   parameter logic [BUS_W-1:0]        ID_VAL   = 32'h001B_B098,
   parameter bit                      SET_PRIO = 1'b1,
   localparam int                     NW       = 2 * NCH,
   localparam int                     FLAT     = NCH * DW
) (
   input  logic             pclk,
   input  logic             presetn,
   input  logic             psel,
   input  logic             penable,
   input  logic             pwrite,
   input  logic [AW-1:0]    paddr,
   input  logic [BUS_W-1:0] pwdata,
   output logic [BUS_W-1:0] prdata,
   output logic             pready,
   output logic             pslverr,
   input  logic [FLAT-1:0]  rmt_rx_set,
   input  logic [FLAT-1:0]  rmt_tx_clr,
   output logic [NCH-1:0]   irq
);
   if (DW < 1 || DW > BUS_W) begin : g_bad_dw
      $error("dbmb_unit: DW must lie in 1..%0d", BUS_W);
   end
   if (NCH < 1) begin : g_bad_nch
      $error("dbmb_unit: NCH must be at least 1");
   end

   logic [NW-1:0]         m_stat, m_set, m_clr;
   logic                  m_id;
   reg_kind_e             kind;
   logic                  wr_en, rd_en;
   logic [NW-1:0][DW-1:0] q_all, set_all, clr_all;
   logic [NCH-1:0]        rx_set_any;

   dbmb_decode #(
      .NCH(NCH), .AW(AW), .CH_BASE(CH_BASE), .TX_OFS(TX_OFS), .ID_OFS(ID_OFS)
   ) i_dec (
      .addr(paddr), .m_stat(m_stat), .m_set(m_set), .m_clr(m_clr),
      .m_id(m_id), .kind(kind)
   );

   assign wr_en   = psel & penable & pwrite;
   assign rd_en   = psel & ~pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   for (genvar w = 0; w < NW; w++) begin : g_word
      localparam int CH = w / 2;
      logic [DW-1:0] loc_set, loc_clr;
      assign loc_set = (wr_en && m_set[w]) ? pwdata[DW-1:0] : '0;
      assign loc_clr = (wr_en && m_clr[w]) ? pwdata[DW-1:0] : '0;

      if ((w % 2) == 0) begin : g_rx
         assign set_all[w] = loc_set | rmt_rx_set[CH*DW +: DW];
         assign clr_all[w] = loc_clr;
         assign irq[CH]    = |q_all[w];
         assign rx_set_any[CH] = |set_all[w];
      end else begin : g_tx
         assign set_all[w] = loc_set;
         assign clr_all[w] = loc_clr | rmt_tx_clr[CH*DW +: DW];
      end

      dbmb_word #(.DW(DW), .SET_PRIO(SET_PRIO)) i_word (
         .clk(pclk), .rst_n(presetn), .set_v(set_all[w]), .clr_v(clr_all[w]),
         .q(q_all[w])
      );
   end

   always_comb begin
      prdata = '0;
      if (rd_en) begin
         if (m_id) prdata = ID_VAL;
         for (int w = 0; w < NW; w++) begin
            if (m_stat[w]) prdata = BUS_W'(q_all[w]);
         end
      end
   end

   AST_DEC_ONEHOT: assert property (@(posedge pclk) disable iff (!presetn)
      psel |-> $onehot0({m_stat, m_set, m_clr, m_id})); // R2

   AST_RD_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && !m_id && !(|m_stat)) |-> (prdata == '0)); // R9

   for (genvar c = 0; c < NCH; c++) begin : g_irq_chk
      AST_IRQ_CAUSE: assert property (@(posedge pclk) disable iff (!presetn)
         $rose(irq[c]) |-> $past(rx_set_any[c])); // R7
   end
endmodule

// File: tb/test_dbmb_unit.sv
module test_dbmb_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 3;
   localparam int DW  = 32;

   logic              pclk = 1'b0;
   logic              presetn = 1'b0;
   logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0]       paddr = '0;
   logic [31:0]       pwdata = '0;
   logic [31:0]       prdata;
   logic              pready, pslverr;
   logic [NCH*DW-1:0] rmt_rx_set = '0, rmt_tx_clr = '0;
   logic [NCH*DW-1:0] pend_rx = '0, pend_tx = '0;
   logic [NCH-1:0]    irq;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) pclk = ~pclk;

   dbmb_unit i_dbmb_unit (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .rmt_rx_set(rmt_rx_set),
      .rmt_tx_clr(rmt_tx_clr), .irq(irq)
   );

   // address map from R2
   function automatic logic [11:0] grp(int ch, int dir);
      logic [11:0] b;
      b = (ch == 0) ? 12'h000 : (ch == 1) ? 12'h020 : 12'h200;
      return b + ((dir == 1) ? 12'h100 : 12'h000);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apb_wr(logic [11:0] a, logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1; rmt_rx_set = pend_rx; rmt_tx_clr = pend_tx;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      rmt_rx_set = '0; rmt_tx_clr = '0; pend_rx = '0; pend_tx = '0;
   endtask

   task automatic apb_rd(logic [11:0] a, output logic [31:0] d,
                         output logic rdy, output logic err);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      d = prdata; rdy = pready; err = pslverr;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
      logic [31:0] d;
      logic r, e;
      apb_rd(a, d, r, e);
      check(req, d, exp);
   endtask

   task automatic clear_all();
      for (int c = 0; c < NCH; c++)
         for (int d = 0; d < 2; d++) apb_wr(grp(c, d) + 12'h10, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      logic r, e;
      check("R1 irq", 32'(irq), 32'h0);
      for (int c = 0; c < NCH; c++)
         for (int dr = 0; dr < 2; dr++) rd_check("R1 status", grp(c, dr), 32'h0);
      apb_rd(12'h000, d, r, e);
      check("R1 pready", 32'(r), 32'h1);
      check("R1 pslverr", 32'(e), 32'h0);
   endtask

   task automatic t_map_set();
      for (int w = 0; w < 6; w++) apb_wr(grp(w/2, w%2) + 12'h08, 32'h11 << (w*4));
      for (int w = 0; w < 6; w++) rd_check("R2 map", grp(w/2, w%2), 32'h11 << (w*4));
      check("R7 irq all rx", 32'(irq), 32'h7);
      apb_wr(grp(0, 0) + 12'h08, 32'h8000_0000);
      rd_check("R3 set keeps others", grp(0, 0), 32'h8000_0011);
      clear_all();
      check("R7 irq after clear", 32'(irq), 32'h0);
   endtask

   task automatic t_clear();
      apb_wr(grp(0, 0) + 12'h08, 32'hF0F0_000F);
      apb_wr(grp(0, 0) + 12'h10, 32'h0000_0003);
      rd_check("R4 partial clear", grp(0, 0), 32'hF0F0_000C);
      check("R7 irq still high", 32'(irq[0]), 32'h1);
      apb_wr(grp(0, 0) + 12'h10, 32'hF0F0_000C);
      check("R7 irq low next cycle", 32'(irq[0]), 32'h0);
      rd_check("R4 all cleared", grp(0, 0), 32'h0);
   endtask

   task automatic t_remote();
      @(negedge pclk);
      rmt_rx_set[1*32 + 5] = 1'b1;
      @(negedge pclk);
      rmt_rx_set = '0;
      check("R7 irq ch1", 32'(irq), 32'h2);
      rd_check("R5 peer set", grp(1, 0), 32'h0000_0020);
      apb_wr(grp(2, 1) + 12'h08, 32'h8000_0001);
      check("R7 tx no irq", 32'(irq), 32'h2);
      rd_check("R5 tx pending", grp(2, 1), 32'h8000_0001);
      @(negedge pclk);
      rmt_tx_clr[2*32 + 0] = 1'b1;
      @(negedge pclk);
      rmt_tx_clr = '0;
      rd_check("R5 tx done", grp(2, 1), 32'h8000_0000);
      clear_all();
   endtask

   task automatic t_set_wins();
      apb_wr(grp(0, 0) + 12'h08, 32'h0000_0200);
      pend_rx[0*32 + 9] = 1'b1;
      apb_wr(grp(0, 0) + 12'h10, 32'h0000_0200);
      rd_check("R6 rx set wins", grp(0, 0), 32'h0000_0200);
      pend_tx[1*32 + 4] = 1'b1;
      apb_wr(grp(1, 1) + 12'h08, 32'h0000_0010);
      rd_check("R6 tx set wins", grp(1, 1), 32'h0000_0010);
   endtask

   task automatic t_strobe_reads();
      rd_check("R8 set reads zero", grp(0, 0) + 12'h08, 32'h0);
      rd_check("R8 clr reads zero", grp(1, 1) + 12'h10, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      logic r, e;
      apb_wr(12'h040, 32'hFFFF_FFFF);
      apb_wr(12'h018, 32'hFFFF_FFFF);
      apb_rd(12'h044, d, r, e);
      check("R9 unmapped read", d, 32'h0);
      check("R9 pready", 32'(r), 32'h1);
      check("R9 pslverr", 32'(e), 32'h0);
      rd_check("R9 rx0 untouched", grp(0, 0), 32'h0000_0200);
      rd_check("R9 tx2 untouched", grp(2, 1), 32'h0);
   endtask

   task automatic t_ident();
      rd_check("R10 id", 12'hFF0, 32'h001B_B098);
      apb_wr(12'hFF0, 32'h0);
      rd_check("R10 id after write", 12'hFF0, 32'h001B_B098);
   endtask

   initial begin
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      t_reset();
      t_map_set();
      t_clear();
      t_remote();
      t_set_wins();
      t_strobe_reads();
      t_unmapped();
      t_ident();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge pclk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule